// File: doc/BRIEF.md
# Truncatable Bus Cycle Timing Generator

This block produces the strobe timing of one read/write cycle on a dataway-style backplane. A single token travels along a one-hot shift register that advances one stage per clock. Fixed stage windows decode the token into a first strobe (S1) and a second strobe (S2). With the default 16 stages and a 10 MHz clock, a full cycle takes 1.6 µs in 100 ns steps. The surrounding sequencer raises `start` to launch a cycle. It watches `busy` and `cyc_done` to learn when the cycle has finished.

The `trunc` input is sampled when a cycle is launched and selects the short form. In the short form the token is removed at the last S1 stage, so S2 never appears and the next bus operation can begin sooner. The `suspend` input holds off new cycles while the sequencer is busy with other work. A cycle that is already running is not affected by it. The control pins are plain levels with no handshake.

Top module: `cycle_timer`

## Requirements
- R1: After reset is released, and in the cycle after `clr` is sampled high, `busy`, `strobe_s1`, `strobe_s2` and `cyc_done` are all 0. While `busy` is 0 the other three outputs stay 0.
- R2: When `start` is 1, `suspend` is 0, `clr` is 0 and `busy` is 0 at a clock edge, the cycle is launched. `busy` is 1 from that edge onward. In a full cycle `busy` stays 1 for exactly STAGES (16) clocks.
- R3: Count clock edges from the launch edge, which is stage 0. `strobe_s1` is 1 in stages S1_FIRST..S1_LAST (3..6), and `strobe_s2` is 1 in stages S2_FIRST..S2_LAST (9..12) of a full cycle.
- R4: `strobe_s1` and `strobe_s2` are never 1 together, and within a cycle S2 only follows S1.
- R5: A cycle launched with `trunc` = 1 never raises `strobe_s2`. Its `busy` ends after stage S1_LAST, so it lasts 7 clocks.
- R6: `cyc_done` is a single-clock pulse in the last busy stage of each cycle. That is stage S1_LAST for a short cycle and stage STAGES-1 for a full cycle. `busy` is 0 in the clock after the pulse.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running cycle neither restarts nor lengthens.
- R8: While `suspend` is 1, no cycle is launched.
- R9: A change on `trunc` after the launch edge does not change the form of the running cycle.
- R10: A `clr` during a cycle ends it at once without a `cyc_done` pulse. A `start` sampled in the same clock as `clr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr | input | 1 | Synchronous clear to idle |
| start | input | 1 | Request to launch a cycle |
| trunc | input | 1 | Select short cycle, sampled at launch |
| suspend | input | 1 | Hold off new cycles |
| busy | output | 1 | Cycle in progress |
| strobe_s1 | output | 1 | First strobe |
| strobe_s2 | output | 1 | Second strobe, full cycles only |
| cyc_done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The hardest cases to reach involve an input that changes in the very clock when the token sits at a boundary. Examples are a `start` in the final busy stage, a `trunc` flip just after launch, and a `clr` that coincides with a `start`. Directed sequences place these events at exact stage counts. After that, long runs of random `start`, `trunc`, `suspend` and rare `clr` levels shift repeatedly against the cycle phase. Every clock is compared with a stage-counter model in the bench.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  localparam int unsigned DEF_STAGES   = 16;
  localparam int unsigned DEF_S1_FIRST = 3;
  localparam int unsigned DEF_S1_LAST  = 6;
  localparam int unsigned DEF_S2_FIRST = 9;
  localparam int unsigned DEF_S2_LAST  = 12;

  typedef enum logic { CYC_FULL = 1'b0, CYC_SHORT = 1'b1 } cyc_form_e;
endpackage

// File: rtl/cyc_launch.sv
module cyc_launch
  import cycle_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      start,
  input  logic      trunc,
  input  logic      suspend,
  input  logic      busy,
  output logic      load,
  output cyc_form_e form_q
);
  assign load = start & ~suspend & ~busy & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     form_q <= CYC_FULL;
    else if (clr)   form_q <= CYC_FULL;
    else if (load)  form_q <= trunc ? CYC_SHORT : CYC_FULL;
  end
endmodule

// File: rtl/cyc_timebase.sv
module cyc_timebase #(
  parameter int unsigned STAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              cut,
  output logic [STAGES-1:0] tap
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = load;
    end else begin : g_body
      assign nxt = tap[i-1] & ~cut;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tap[i] <= 1'b0;
      else if (clr) tap[i] <= 1'b0;
      else          tap[i] <= nxt;
    end
  end
endmodule

// File: rtl/cyc_strobe_dec.sv
module cyc_strobe_dec
  import cycle_timer_pkg::*;
#(
  parameter int unsigned STAGES   = 16,
  parameter int unsigned S1_FIRST = 3,
  parameter int unsigned S1_LAST  = 6,
  parameter int unsigned S2_FIRST = 9,
  parameter int unsigned S2_LAST  = 12
) (
  input  logic [STAGES-1:0] tap,
  input  cyc_form_e         form_q,
  output logic              busy,
  output logic              s1,
  output logic              s2,
  output logic              done,
  output logic              cut
);
  logic short_c;
  assign short_c = (form_q == CYC_SHORT);
  assign busy = |tap;
  assign s1   = |tap[S1_LAST:S1_FIRST];
  assign s2   = ~short_c & (|tap[S2_LAST:S2_FIRST]);
  assign cut  = short_c & tap[S1_LAST];
  assign done = short_c ? tap[S1_LAST] : tap[STAGES-1];
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
#(
  parameter int unsigned STAGES   = DEF_STAGES,
  parameter int unsigned S1_FIRST = DEF_S1_FIRST,
  parameter int unsigned S1_LAST  = DEF_S1_LAST,
  parameter int unsigned S2_FIRST = DEF_S2_FIRST,
  parameter int unsigned S2_LAST  = DEF_S2_LAST
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic trunc,
  input  logic suspend,
  output logic busy,
  output logic strobe_s1,
  output logic strobe_s2,
  output logic cyc_done
);
  logic [STAGES-1:0] tap;
  logic              load;
  logic              cut;
  cyc_form_e         form_q;

  cyc_launch u_launch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .trunc(trunc),
    .suspend(suspend), .busy(busy), .load(load), .form_q(form_q)
  );

  cyc_timebase #(.STAGES(STAGES)) u_tb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .cut(cut), .tap(tap)
  );

  cyc_strobe_dec #(
    .STAGES(STAGES), .S1_FIRST(S1_FIRST), .S1_LAST(S1_LAST),
    .S2_FIRST(S2_FIRST), .S2_LAST(S2_LAST)
  ) u_dec (
    .tap(tap), .form_q(form_q), .busy(busy), .s1(strobe_s1),
    .s2(strobe_s2), .done(cyc_done), .cut(cut)
  );
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic start,
  input logic suspend,
  input logic busy,
  input logic strobe_s1,
  input logic strobe_s2,
  input logic cyc_done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!strobe_s1 && !strobe_s2 && !cyc_done)); // R1
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !busy); // R10
  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !suspend && !clr && !busy) |=> busy); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_s1 && strobe_s2)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !busy); // R6
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && suspend) |=> !busy); // R8
endmodule

bind cycle_timer cycle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .suspend(suspend),
  .busy(busy), .strobe_s1(strobe_s1), .strobe_s2(strobe_s2), .cyc_done(cyc_done)
);

// File: tb/sim_cycle_timer.sv
module sim_cycle_timer;
  localparam int STG = 16, A1 = 3, B1 = 6, A2 = 9, B2 = 12;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, start = 1'b0, trunc = 1'b0, suspend = 1'b0;
  logic busy, strobe_s1, strobe_s2, cyc_done;
  int checks = 0, errors = 0, cycles = 0;
  int pos = -1;          // model stage, -1 idle
  bit mtr = 1'b0;        // model short form
  bit mon_on = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  cycle_timer u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .trunc(trunc),
    .suspend(suspend), .busy(busy), .strobe_s1(strobe_s1), .strobe_s2(strobe_s2),
    .cyc_done(cyc_done));

  function automatic int last_of(bit t); return t ? B1 : STG - 1; endfunction
  function automatic bit e_busy(int p); return p >= 0; endfunction
  function automatic bit e_s1(int p); return p >= A1 && p <= B1; endfunction
  function automatic bit e_s2(int p, bit t); return !t && p >= A2 && p <= B2; endfunction
  function automatic bit e_done(int p, bit t); return p >= 0 && p == last_of(t); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= -1;
    else if (clr) pos <= -1;
    else if (pos < 0) begin
      if (start && !suspend) begin pos <= 0; mtr <= trunc; end
    end else if (pos == last_of(mtr)) pos <= -1;
    else pos <= pos + 1;
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
    if (mon_on) begin
      chk("busy", busy, e_busy(pos));           // R2
      chk("s1", strobe_s1, e_s1(pos));          // R3
      chk("s2", strobe_s2, e_s2(pos, mtr));     // R3 R5
      chk("done", cyc_done, e_done(pos, mtr));  // R6
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(bit t);
    start = 1'b1; trunc = t; step(); start = 1'b0;
  endtask

  initial begin
    int len, s2seen;
    step(2);
    rst_n = 1'b1;
    step();
    tag = "R1";
    chk("reset busy", busy, 1'b0);
    chk("reset done", cyc_done, 1'b0);
    mon_on = 1'b1;

    tag = "R2";
    launch(1'b0);
    len = 0;
    while (busy && len < 40) begin len++; step(); end
    chk("full length 16", len == STG, 1'b1);

    tag = "R5";
    launch(1'b1);
    len = 0; s2seen = 0;
    while (busy && len < 40) begin len++; if (strobe_s2) s2seen++; step(); end
    chk("short length 7", len == B1 + 1, 1'b1);
    chk("short has no s2", s2seen == 0, 1'b1);

    tag = "R9";
    launch(1'b0); trunc = 1'b1; step(12);
    chk("s2 kept after trunc flip", strobe_s2, 1'b1);
    step(10); trunc = 1'b0;
    launch(1'b1); step(8);
    chk("short kept after trunc drop", busy, 1'b0);

    tag = "R7";
    launch(1'b0); start = 1'b1; step(15);
    chk("done at stage 15 despite start", cyc_done, 1'b1);
    step();
    chk("no restart at end edge", busy, 1'b0);
    start = 1'b0; step(3);

    tag = "R8";
    suspend = 1'b1; start = 1'b1; step(20);
    chk("suspend holds off", busy, 1'b0);
    suspend = 1'b0; step();
    chk("launch after suspend", busy, 1'b1);
    start = 1'b0; step(20);

    tag = "R10";
    launch(1'b0); step(9);
    clr = 1'b1; step(); clr = 1'b0;
    chk("clr aborts", busy, 1'b0);
    clr = 1'b1; start = 1'b1; step(); clr = 1'b0; start = 1'b0;
    chk("start with clr ignored", busy, 1'b0);
    step(3);

    tag = "R1";
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("power-on idle", busy, 1'b0);

    tag = "R4";
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 6000; i++) begin
      start   = ($urandom % 4) != 0;
      trunc   = $urandom % 2;
      suspend = ($urandom % 5) == 0;
      clr     = ($urandom % 97) == 0;
      step();
    end
    start = 1'b0; clr = 1'b0; suspend = 1'b0;
    step(20);
    finish_run();
  end
endmodule